// File: doc/BRIEF.md
# Global-history XOR-indexed branch direction predictor

This block guesses whether a conditional branch will be taken. It keeps a single global history register with the outcomes of the branches resolved most recently, 1 for taken and 0 for not taken. It also holds a table of two-bit saturating counters. A lookup hashes the branch address with that history by bitwise XOR and selects one counter. The upper bit of that counter is the prediction. Because the history takes part in the index, one static branch can use different counters depending on how the branches just before it went. This lets the predictor exploit correlation between neighbouring branches.

The lookup path is purely combinational. A fetch stage presents an address and gets back a direction and the table index that produced it in the same cycle. The pipeline carries that index alongside the branch. When the branch resolves, the index and the real outcome come back on the resolve port. The counter at that index moves one step toward the outcome, and the outcome is shifted into the history. The update reaches the counter that made the prediction even if the history has moved on since. One branch resolves per cycle at most.

The parameter `HIST_W` sets both the history length and the table depth of 2^HIST_W counters. `ADDR_LSB` skips the address bits below the instruction alignment.

Top module: `gshare_predictor`

## Requirements
- R1: While rst_n is low (asynchronous), the history becomes all zeros and every counter becomes 1. After reset, every lookup therefore predicts not taken, and `lkp_idx` equals the hashed address bits.
- R2: `lkp_idx` equals `lkp_addr[ADDR_LSB+HIST_W-1:ADDR_LSB]` XOR the current history, combinationally in the same cycle.
- R3: `lkp_taken` is 1 exactly when the counter at `lkp_idx` holds 2 or 3, and 0 when it holds 0 or 1.
- R4: A resolve with `rsv_taken`=1 increments the counter at `rsv_idx` by one. A counter at 3 stays at 3.
- R5: A resolve with `rsv_taken`=0 decrements the counter at `rsv_idx` by one. A counter at 0 stays at 0.
- R6: Each resolve shifts the history left by one position. The outcome enters at bit 0, and the oldest bit (bit HIST_W-1) is dropped.
- R7: A resolve changes only the counter named by `rsv_idx`, whatever address the lookup port carries in that cycle.
- R8: When `rsv_valid` is 0, neither the history nor any counter changes, whatever `rsv_idx` and `rsv_taken` carry.
- R9: A resolve takes effect at the next rising edge. A lookup of the same index in the resolve cycle returns the counter value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously by the surrounding logic |
| lkp_addr | input | ADDR_W | Branch address to predict |
| lkp_taken | output | 1 | Predicted direction, 1 = taken |
| lkp_idx | output | HIST_W | Counter index used for this prediction |
| rsv_valid | input | 1 | A branch resolves this cycle |
| rsv_idx | input | HIST_W | Index returned at lookup time for the resolving branch |
| rsv_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench drives a counter past each end and then steps it back. A design that wraps 3 to 0 or 0 to 3 flips its prediction at that point instead of holding. It resolves into an index other than the one being looked up and checks that a write through the current lookup index shows up as a wrong prediction. It holds `rsv_valid` low with a taken outcome and a live index and confirms through `lkp_idx` (with address zero) that a history which shifts anyway is exposed. It reads a counter in the very cycle it is updated and applies a mid-run reset, so that a bypassed write or a missed counter reinitialisation is caught.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MAX  = 2'd3;
  localparam ctr_t CTR_MIN  = 2'd0;
  localparam ctr_t CTR_INIT = 2'd1;

  // One saturating step toward the resolved outcome.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
    ctr_t nxt;
    if (up) nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else    nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return nxt;
  endfunction

  // Upper half of the counter range means taken.
  function automatic logic ctr_dir(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/gshare_history.sv
module gshare_history #(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_d;
  logic [HIST_W-1:0] hist_q;

  always_comb begin
    hist_d = hist_q;
    if (shift_en) hist_d = {hist_q[HIST_W-2:0], shift_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

  assign hist = hist_q;

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])) && (hist_q[0] == $past(shift_bit)));

  // R8
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/gshare_index.sv
module gshare_index #(
  parameter int HIST_W   = 10,
  parameter int ADDR_W   = 32,
  parameter int ADDR_LSB = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [HIST_W-1:0] hist,
  output logic [HIST_W-1:0] idx
);

  logic [HIST_W-1:0] addr_bits;
  logic              unused_addr;

  assign addr_bits   = addr[ADDR_LSB +: HIST_W];
  assign idx         = addr_bits ^ hist;
  assign unused_addr = ^addr;

endmodule

// File: rtl/gshare_table.sv
module gshare_table
  import gshare_pkg::*;
#(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] rd_idx,
  output logic              rd_dir,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_up
);

  localparam int DEPTH = 1 << HIST_W;

  ctr_t cnt_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ctr
    logic ce;
    ctr_t cnt_d;

    always_comb begin
      ce    = wr_en && (wr_idx == HIST_W'(i));
      cnt_d = ctr_step(cnt_q[i], wr_up);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt_q[i] <= CTR_INIT;
      else if (ce) cnt_q[i] <= cnt_d;
    end
  end

  assign rd_dir = ctr_dir(cnt_q[rd_idx]);

  // R4
  ctr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up) |=>
      cnt_q[$past(wr_idx)] == (($past(cnt_q[wr_idx]) == 2'd3) ? 2'd3 : ($past(cnt_q[wr_idx]) + 2'd1)));

  // R5
  ctr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up) |=>
      cnt_q[$past(wr_idx)] == (($past(cnt_q[wr_idx]) == 2'd0) ? 2'd0 : ($past(cnt_q[wr_idx]) - 2'd1)));

  // R8
  ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> cnt_q[$past(rd_idx)] == $past(cnt_q[rd_idx]));

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor #(
  parameter int HIST_W   = 10,
  parameter int ADDR_W   = 32,
  parameter int ADDR_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              lkp_taken,
  output logic [HIST_W-1:0] lkp_idx,
  input  logic              rsv_valid,
  input  logic [HIST_W-1:0] rsv_idx,
  input  logic              rsv_taken
);

  logic [HIST_W-1:0] hist;

  gshare_history #(.HIST_W(HIST_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (rsv_valid),
    .shift_bit (rsv_taken),
    .hist      (hist)
  );

  gshare_index #(.HIST_W(HIST_W), .ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB)) u_index (
    .addr (lkp_addr),
    .hist (hist),
    .idx  (lkp_idx)
  );

  gshare_table #(.HIST_W(HIST_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (lkp_idx),
    .rd_dir (lkp_taken),
    .wr_en  (rsv_valid),
    .wr_idx (rsv_idx),
    .wr_up  (rsv_taken)
  );

  // R2
  always_comb begin
    if (rst_n) begin
      idx_hash_chk: assert ((lkp_idx ^ hist) == lkp_addr[ADDR_LSB +: HIST_W]);
    end
  end

endmodule

// File: tb/gshare_predictor_test.sv
module gshare_predictor_test;

  localparam int CLK_PERIOD = 10;
  localparam int HIST_W     = 10;
  localparam int ADDR_W     = 32;
  localparam int ADDR_LSB   = 2;
  localparam int DEPTH      = 1 << HIST_W;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] lkp_addr;
  logic              lkp_taken;
  logic [HIST_W-1:0] lkp_idx;
  logic              rsv_valid;
  logic [HIST_W-1:0] rsv_idx;
  logic              rsv_taken;

  gshare_predictor #(.HIST_W(HIST_W), .ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_addr  (lkp_addr),
    .lkp_taken (lkp_taken),
    .lkp_idx   (lkp_idx),
    .rsv_valid (rsv_valid),
    .rsv_idx   (rsv_idx),
    .rsv_taken (rsv_taken)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests;
  int n_fail;
  bit done;

  // Reference state, built from the requirements.
  int                m_cnt [DEPTH];
  logic [HIST_W-1:0] m_hist;

  // Vector: addr[15:0], resolve valid, outcome. The resolve reuses the lookup index.
  localparam logic [17:0] VEC [16] = '{
    {16'h0040, 1'b1, 1'b1}, {16'h0040, 1'b1, 1'b1}, {16'h1234, 1'b1, 1'b0},
    {16'h0040, 1'b1, 1'b1}, {16'h0000, 1'b0, 1'b1}, {16'hFFFC, 1'b1, 1'b1},
    {16'h0040, 1'b1, 1'b1}, {16'h0040, 1'b1, 1'b1}, {16'hABCD, 1'b1, 1'b0},
    {16'h0000, 1'b1, 1'b1}, {16'h0000, 1'b1, 1'b1}, {16'h0000, 1'b1, 1'b1},
    {16'h0010, 1'b0, 1'b0}, {16'h0040, 1'b1, 1'b0}, {16'h0040, 1'b1, 1'b0},
    {16'h7FF0, 1'b1, 1'b1}
  };

  function automatic logic [HIST_W-1:0] m_idx(input logic [ADDR_W-1:0] a);
    return a[ADDR_LSB +: HIST_W] ^ m_hist;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_for(input logic [HIST_W-1:0] k);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[ADDR_LSB +: HIST_W] = k ^ m_hist;
    return a;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < DEPTH; i++) m_cnt[i] = 1;
    m_hist = '0;
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check the lookup mid-cycle, update the model after the edge.
  task automatic step(input logic [ADDR_W-1:0] a, input logic v, input logic t,
                      input logic [HIST_W-1:0] ri, input string tag);
    logic [HIST_W-1:0] ei;
    @(negedge clk);
    lkp_addr  = a;
    rsv_valid = v;
    rsv_taken = t;
    rsv_idx   = ri;
    #1;
    ei = m_idx(a);
    check(32'(lkp_idx), 32'(ei), {tag, " idx"});
    check(32'(lkp_taken), 32'(m_cnt[ei] >= 2), {tag, " dir"});
    @(posedge clk);
    if (v) begin
      if (t) m_cnt[ri] = (m_cnt[ri] == 3) ? 3 : m_cnt[ri] + 1;
      else   m_cnt[ri] = (m_cnt[ri] == 0) ? 0 : m_cnt[ri] - 1;
      m_hist = {m_hist[HIST_W-2:0], t};
    end
  endtask

  task automatic query(input logic [HIST_W-1:0] k, input logic exp_dir, input string tag);
    step(addr_for(k), 1'b0, 1'b0, '0, tag);
    check(32'(lkp_taken), 32'(exp_dir), {tag, " explicit"});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [HIST_W-1:0] k_a;
    logic [HIST_W-1:0] k_b;
    n_tests = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; lkp_addr = '0; rsv_valid = 1'b0; rsv_idx = '0; rsv_taken = 1'b0;
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, history zero, all counters weakly not taken
    step(32'h0000_0000, 1'b0, 1'b0, '0, "R1 reset addr0");
    check(32'(lkp_idx), 32'h0, "R1 reset history zero");
    step(32'h1234_5678, 1'b0, 1'b0, '0, "R1 reset addr");
    check(32'(lkp_taken), 32'h0, "R1 reset not taken");

    // Vector walk: R2 hash, R3 direction, R6 shift
    foreach (VEC[i]) begin
      logic [ADDR_W-1:0] a;
      a = {16'h0, VEC[i][17:2]};
      step(a, VEC[i][1], VEC[i][0], m_idx(a), "R2 R3 R6 vector");
    end
    // R6: history observed through lkp_idx at address zero
    step(32'h0, 1'b0, 1'b0, '0, "R6 history");
    check(32'(lkp_idx), 32'(m_hist), "R6 history value");

    // R4: upper saturation
    k_a = 10'h155;
    for (int i = 0; i < 5; i++) step(32'h0, 1'b1, 1'b1, k_a, "R4 drive up");
    query(k_a, 1'b1, "R4 at max");
    step(32'h0, 1'b1, 1'b0, k_a, "R4 step down");
    query(k_a, 1'b1, "R4 saturated then 2");
    step(32'h0, 1'b1, 1'b0, k_a, "R4 step down");
    query(k_a, 1'b0, "R4 now 1");

    // R5: lower saturation
    for (int i = 0; i < 4; i++) step(32'h0, 1'b1, 1'b0, k_a, "R5 drive down");
    step(32'h0, 1'b1, 1'b1, k_a, "R5 step up");
    query(k_a, 1'b0, "R5 saturated then 1");
    step(32'h0, 1'b1, 1'b1, k_a, "R5 step up");
    query(k_a, 1'b1, "R5 now 2");

    // R7: resolve elsewhere while looking up another index
    k_b = 10'h0AA;
    for (int i = 0; i < 3; i++) step(addr_for(k_b), 1'b1, 1'b1, k_a ^ 10'h3FF, "R7 lookup other");
    query(k_b, 1'b0, "R7 lookup counter untouched");

    // R8: invalid resolve changes nothing
    begin
      logic [HIST_W-1:0] h0;
      h0 = m_hist;
      for (int i = 0; i < 4; i++) step(addr_for(k_b), 1'b0, 1'b1, k_b, "R8 idle");
      step(32'h0, 1'b0, 1'b1, k_b, "R8 history");
      check(32'(lkp_idx), 32'(h0), "R8 history held");
      query(k_b, 1'b0, "R8 counter held");
    end

    // R9: same-cycle read of the index being written sees the old value
    step(addr_for(k_b), 1'b1, 1'b1, k_b, "R9 old value 1");
    query(k_b, 1'b1, "R9 new value 2 next cycle");

    // R1: mid-run reset reverts everything
    @(negedge clk) rst_n = 1'b0;
    m_reset();
    @(negedge clk) rst_n = 1'b1;
    step(32'h0, 1'b0, 1'b0, '0, "R1 rerun history");
    check(32'(lkp_idx), 32'h0, "R1 rerun history zero");
    query(k_b, 1'b0, "R1 rerun counter 1");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule